// File: doc/BRIEF.md
# Indirect Pointer Unit

This block keeps three 12-bit data-memory pointers. It turns CPU accesses aimed at a set of virtual register addresses into real accesses on a 4096-byte data memory. The CPU presents one file-register access per clock: an address, a write strobe, write data and the current W value. When the address is one of the five virtual slots that belong to a pointer, the block works out the effective address from that pointer. It then drives the memory port or one of its own pointer bytes, and steps the pointer as the slot requires.

The virtual slots and the six pointer bytes sit in a fixed window from FD9h to FEFh. Each pointer owns eight consecutive addresses in that window. Addresses outside the window, and the two gaps at FE0h and FE8h, pass straight through to the memory. An indirect access can land back on a virtual slot. A read of that kind returns zero and raises a zero hint, and a write of that kind does nothing. An indirect write that lands on a pointer's own byte overrides that pointer's automatic step.

Top module: `indirect_ptr_unit`

## Requirements
- R1: After reset all three pointers are 000h. Pointer n's low byte reads at FE9h-8n and its high byte at FEAh-8n. The high byte returns the pointer's upper 4 bits in bits 3:0, with bits 7:4 reading 0.
- R2: For pointer n, the virtual slots are: plain at FEFh-8n, post-decrement at FEEh-8n, post-increment at FEDh-8n, pre-increment at FECh-8n and W-indexed at FEBh-8n. Every other address, including FE0h, FE8h and anything outside FD9h..FEFh, is passed to memory unchanged.
- R3: A plain-slot access uses the pointer as the effective address and leaves the pointer unchanged.
- R4: Post-increment and post-decrement use the current pointer as the address. The pointer then becomes pointer+1 or pointer-1 modulo 4096, and the next access sees the new value (FFFh steps to 000h, 000h steps to FFFh).
- R5: Pre-increment uses pointer+1 (modulo 4096) as the address and leaves the pointer at that value.
- R6: A W-indexed access uses pointer plus W, with W read as a signed 8-bit value, modulo 4096. Neither the pointer nor W changes.
- R7: An access changes at most the pointer it steps and the pointer whose byte it writes. All other pointers hold their values.
- R8: If the effective address of an indirect access is a virtual slot, a read returns 00h with rd_zero_hint high. A write to such an address causes no memory write and changes no pointer byte, though the stepping pointer still steps.
- R9: rd_zero_hint is low for every access other than the case in R8, including a pointer stepping to 000h.
- R10: When an indirect write lands on a byte of the same pointer that is stepping, the pointer becomes the written byte joined with its other byte as it was before the access, and the step is discarded.
- R11: The memory port (mem_en, mem_we, mem_addr, mem_wdata) is driven combinationally in the access cycle and is idle when acc_en is low. rd_data and rd_zero_hint belong to the access of the previous cycle.
- R12: A write to a pointer byte, direct or indirect, loads that byte. A high-byte write keeps only bits 3:0.
- R13: An indirect write that lands on a byte of another pointer loads that byte, and the addressing pointer still steps in the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | File-register access this cycle |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 12 | File-register address |
| acc_wdata | input | 8 | Write data |
| w_val | input | 8 | Working-register value, signed index for W-indexed slots |
| rd_data | output | 8 | Read result of the previous cycle's access |
| rd_zero_hint | output | 1 | Previous read hit a virtual slot indirectly |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Synchronous memory read data, valid the cycle after mem_en |

## Verification
The hard cases are the indirect accesses whose effective address lands back inside the pointer window. Only then do the null read and write, the own-byte write override and the write to another pointer's byte take place. To reach them, the pointers must first be loaded with window addresses through their byte registers. The bench does this directly for each of those cases. Its random phase also biases pointer high bytes toward Fh and low bytes toward D8h..EFh, so that stepping and W-indexing keep crossing in and out of the window.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  // slot code = position of an address inside a pointer's 8-address group
  typedef enum logic [2:0] {
    SLOT_NONE    = 3'd0,
    SLOT_LO      = 3'd1,
    SLOT_HI      = 3'd2,
    SLOT_INDEXW  = 3'd3,
    SLOT_PREINC  = 3'd4,
    SLOT_POSTINC = 3'd5,
    SLOT_POSTDEC = 3'd6,
    SLOT_PLAIN   = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    TK_RAM   = 2'd0,
    TK_VIRT  = 2'd1,
    TK_PBYTE = 2'd2
  } tkind_e;

  typedef struct packed {
    tkind_e     kind;
    logic [1:0] sel;
    slot_e      slot;
  } tgt_t;
endpackage

// File: rtl/ipu_decode.sv
module ipu_decode
  import ipu_pkg::*;
#(
  parameter int             AW      = 12,
  parameter int             NPTR    = 3,
  parameter logic [AW-1:0]  WIN_TOP = 12'hFEF
) (
  input  logic [AW-1:0] addr,
  output tgt_t          tgt
);
  localparam logic [AW-1:0] WIN_SPAN = AW'(8 * NPTR);
  localparam logic [AW-1:0] WIN_BASE = WIN_TOP - WIN_SPAN + AW'(1);

  logic [AW-1:0] idx;
  logic [2:0]    off;
  logic [AW-4:0] grp;
  logic          in_win;

  always_comb begin
    idx    = addr - WIN_BASE;
    off    = idx[2:0];
    grp    = idx[AW-1:3];
    in_win = (addr >= WIN_BASE) && (addr <= WIN_TOP) && (off != 3'd0);
    tgt.kind = TK_RAM;
    tgt.sel  = '0;
    tgt.slot = SLOT_NONE;
    if (in_win) begin
      // highest group belongs to pointer 0
      tgt.sel  = 2'(NPTR - 1 - int'(grp));
      tgt.slot = slot_e'(off);
      tgt.kind = (off >= 3'd3) ? TK_VIRT : TK_PBYTE;
    end
  end
endmodule

// File: rtl/ipu_agu.sv
module ipu_agu
  import ipu_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] w,
  input  slot_e         slot,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] w_ext;

  always_comb begin
    w_ext = {{(AW-DW){w[DW-1]}}, w};
    case (slot)
      SLOT_PREINC: ea = ptr + AW'(1);
      SLOT_INDEXW: ea = ptr + w_ext;
      default:     ea = ptr;
    endcase
  end
endmodule

// File: rtl/ipu_ptr_bank.sv
module ipu_ptr_bank
  import ipu_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int NPTR = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mod_en,
  input  logic [1:0]               mod_sel,
  input  slot_e                    mod_slot,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic                     wr_hi,
  input  logic [DW-1:0]            wr_data,
  output logic [NPTR-1:0][AW-1:0]  ptrs
);
  localparam int HW = AW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrs <= '0;
    end else begin
      for (int i = 0; i < NPTR; i++) begin
        if (wr_en && (wr_sel == 2'(i))) begin
          // a byte write beats any step of the same pointer
          if (wr_hi) ptrs[i][AW-1:DW] <= wr_data[HW-1:0];
          else       ptrs[i][DW-1:0]  <= wr_data;
        end else if (mod_en && (mod_sel == 2'(i))) begin
          case (mod_slot)
            SLOT_POSTDEC:              ptrs[i] <= ptrs[i] - AW'(1);
            SLOT_POSTINC, SLOT_PREINC: ptrs[i] <= ptrs[i] + AW'(1);
            default:                   ptrs[i] <= ptrs[i];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/indirect_ptr_unit.sv
module indirect_ptr_unit
  import ipu_pkg::*;
#(
  parameter int            AW      = 12,
  parameter int            DW      = 8,
  parameter int            NPTR    = 3,
  parameter logic [AW-1:0] WIN_TOP = 12'hFEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] w_val,
  output logic [DW-1:0] rd_data,
  output logic          rd_zero_hint,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  tgt_t                     dir_t;
  tgt_t                     res_t;
  logic [NPTR-1:0][AW-1:0]  ptrs;
  logic [AW-1:0]            base;
  logic [AW-1:0]            ea;
  logic [AW-1:0]            tgt_addr;
  logic                     indirect;
  logic [DW-1:0]            pbyte_val;
  logic                     mod_en;
  logic                     wr_en;
  logic                     wr_hi;
  logic                     rd_acc;
  logic                     from_mem_q;
  logic [DW-1:0]            hold_q;
  logic                     zero_q;

  // first decode: what the CPU named
  ipu_decode #(.AW(AW), .NPTR(NPTR), .WIN_TOP(WIN_TOP)) u_dec_dir (
    .addr (acc_addr),
    .tgt  (dir_t)
  );

  assign indirect = (dir_t.kind == TK_VIRT);
  assign base     = ptrs[dir_t.sel];

  ipu_agu #(.AW(AW), .DW(DW)) u_agu (
    .ptr  (base),
    .w    (w_val),
    .slot (dir_t.slot),
    .ea   (ea)
  );

  assign tgt_addr = indirect ? ea : acc_addr;

  // second decode: where the access really lands
  ipu_decode #(.AW(AW), .NPTR(NPTR), .WIN_TOP(WIN_TOP)) u_dec_res (
    .addr (tgt_addr),
    .tgt  (res_t)
  );

  assign wr_hi     = (res_t.slot == SLOT_HI);
  assign pbyte_val = wr_hi ? DW'(ptrs[res_t.sel][AW-1:DW]) : ptrs[res_t.sel][DW-1:0];
  assign mod_en    = acc_en && indirect;
  assign wr_en     = acc_en && acc_we && (res_t.kind == TK_PBYTE);
  assign rd_acc    = acc_en && !acc_we;

  ipu_ptr_bank #(.AW(AW), .DW(DW), .NPTR(NPTR)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .mod_en   (mod_en),
    .mod_sel  (dir_t.sel),
    .mod_slot (dir_t.slot),
    .wr_en    (wr_en),
    .wr_sel   (res_t.sel),
    .wr_hi    (wr_hi),
    .wr_data  (acc_wdata),
    .ptrs     (ptrs)
  );

  assign mem_en    = acc_en && (res_t.kind == TK_RAM);
  assign mem_we    = mem_en && acc_we;
  assign mem_addr  = tgt_addr;
  assign mem_wdata = acc_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      from_mem_q <= 1'b0;
      hold_q     <= '0;
      zero_q     <= 1'b0;
    end else begin
      from_mem_q <= rd_acc && (res_t.kind == TK_RAM);
      hold_q     <= (rd_acc && (res_t.kind == TK_PBYTE)) ? pbyte_val : '0;
      zero_q     <= rd_acc && (res_t.kind == TK_VIRT);
    end
  end

  assign rd_data      = from_mem_q ? mem_rdata : hold_q;
  assign rd_zero_hint = zero_q;
endmodule

// File: rtl/ipu_chk.sv
module ipu_chk
  import ipu_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int NPTR = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    acc_en,
  input logic                    acc_we,
  input logic [DW-1:0]           rd_data,
  input logic                    rd_zero_hint,
  input logic                    mem_en,
  input logic                    mem_we,
  input logic [NPTR-1:0][AW-1:0] ptrs,
  input logic                    mod_en,
  input logic [1:0]              mod_sel,
  input slot_e                   mod_slot,
  input logic                    wr_en,
  input logic [1:0]              wr_sel,
  input logic                    wr_hi,
  input logic [DW-1:0]           wr_data
);
  assert_null_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    rd_zero_hint |-> (rd_data == '0));

  assert_hint_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_zero_hint |-> $past(acc_en && !acc_we));

  assert_port_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_en |-> acc_en) and (mem_we |-> acc_we));

  for (genvar i = 0; i < NPTR; i++) begin : g_p
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
      !((mod_en && mod_sel == 2'(i)) || (wr_en && wr_sel == 2'(i)))
      |=> (ptrs[i] == $past(ptrs[i])));

    assert_postinc_step_R4: assert property (@(posedge clk) disable iff (rst)
      (mod_en && mod_sel == 2'(i) && mod_slot == SLOT_POSTINC && !(wr_en && wr_sel == 2'(i)))
      |=> (ptrs[i] == $past(ptrs[i]) + AW'(1)));

    assert_postdec_step_R4: assert property (@(posedge clk) disable iff (rst)
      (mod_en && mod_sel == 2'(i) && mod_slot == SLOT_POSTDEC && !(wr_en && wr_sel == 2'(i)))
      |=> (ptrs[i] == $past(ptrs[i]) - AW'(1)));

    assert_indexw_keeps_R6: assert property (@(posedge clk) disable iff (rst)
      (mod_en && mod_sel == 2'(i) && mod_slot == SLOT_INDEXW && !wr_en)
      |=> $stable(ptrs[i]));

    assert_own_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && mod_en && wr_sel == 2'(i) && mod_sel == 2'(i) && !wr_hi)
      |=> (ptrs[i][DW-1:0] == $past(wr_data)) && (ptrs[i][AW-1:DW] == $past(ptrs[i][AW-1:DW])));
  end
endmodule

bind indirect_ptr_unit ipu_chk #(.AW(AW), .DW(DW), .NPTR(NPTR)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acc_en       (acc_en),
  .acc_we       (acc_we),
  .rd_data      (rd_data),
  .rd_zero_hint (rd_zero_hint),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .ptrs         (ptrs),
  .mod_en       (mod_en),
  .mod_sel      (dir_t.sel),
  .mod_slot     (dir_t.slot),
  .wr_en        (wr_en),
  .wr_sel       (res_t.sel),
  .wr_hi        (wr_hi),
  .wr_data      (acc_wdata)
);

// File: tb/indirect_ptr_unit_bench.sv
module indirect_ptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0, w_val = '0;
  logic [7:0]  rd_data;
  logic        rd_zero_hint;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  dmem [4096];
  logic [7:0]  shadow [4096];
  int          mp [3];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  indirect_ptr_unit u_indirect_ptr_unit (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .w_val(w_val), .rd_data(rd_data), .rd_zero_hint(rd_zero_hint),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) dmem[mem_addr] <= mem_wdata;
      mem_rdata <= dmem[mem_addr];
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // group member: 7 plain, 6 postdec, 5 postinc, 4 preinc, 3 indexw, 2 hi, 1 lo, 0 memory
  task automatic classify(input int a, output int p, output int off);
    if (a >= 'hFD8 && a <= 'hFEF && ((a - 'hFD8) % 8) != 0) begin
      p   = 2 - (a - 'hFD8) / 8;
      off = (a - 'hFD8) % 8;
    end else begin
      p = 0; off = 0;
    end
  endtask

  function automatic int slot_addr(input int p, input int off);
    return 'hFE8 - 8 * p + off;
  endfunction

  task automatic access(input int a, input bit we, input int wd, input int w, input string tg);
    int p1, o1, p2, o2, ea, rd;
    bit ind, nul, zero, men;
    string tag;
    int np [3];
    classify(a, p1, o1);
    ind = (o1 >= 3);
    ea  = a;
    if (ind) begin
      case (o1)
        4: ea = (mp[p1] + 1) & 'hFFF;
        3: ea = (mp[p1] + ((w >= 128) ? w - 256 : w)) & 'hFFF;
        default: ea = mp[p1];
      endcase
    end
    classify(ea, p2, o2);
    case (o1)
      7: tag = "R3";
      6, 5: tag = "R4";
      4: tag = "R5";
      3: tag = "R6";
      default: tag = "R2";
    endcase
    if (tg != "") tag = tg;
    np = mp;
    if (ind) begin
      if (o1 == 6) np[p1] = (mp[p1] - 1) & 'hFFF;
      if (o1 == 5 || o1 == 4) np[p1] = (mp[p1] + 1) & 'hFFF;
    end
    rd = 0; nul = 0; zero = 0; men = 0;
    if (o2 >= 3) begin
      nul = 1; zero = !we;
    end else if (o2 == 1 || o2 == 2) begin
      rd = (o2 == 2) ? (mp[p2] >> 8) : (mp[p2] & 'hFF);
      if (we) np[p2] = (o2 == 2) ? (((wd & 'hF) << 8) | (mp[p2] & 'hFF))
                                 : ((mp[p2] & 'hF00) | (wd & 'hFF));
    end else begin
      men = 1; rd = shadow[ea];
    end
    acc_en = 1; acc_we = we; acc_addr = a[11:0]; acc_wdata = wd[7:0]; w_val = w[7:0];
    #1;
    check(nul ? "R8" : "R11", int'(mem_en), int'(men), "mem_en");
    if (men) begin
      check(tag, int'(mem_addr), ea, "mem_addr");
      check("R11", int'(mem_we), int'(we), "mem_we");
      if (we) begin
        check("R11", int'(mem_wdata), wd & 'hFF, "mem_wdata");
        shadow[ea] = wd[7:0];
      end
    end
    @(negedge clk);
    acc_en = 0; acc_we = 0;
    if (!we) check(zero ? "R8" : tag, int'(rd_data), rd, "rd_data");
    check(zero ? "R8" : "R9", int'(rd_zero_hint), int'(zero), "rd_zero_hint");
    mp = np;
  endtask

  task automatic set_ptr(input int p, input int v);
    access(slot_addr(p, 2), 1, (v >> 8) & 'hF, 0, "R12");
    access(slot_addr(p, 1), 1, v & 'hFF, 0, "R12");
  endtask

  task automatic read_all(input string tg);
    for (int p = 0; p < 3; p++) begin
      access(slot_addr(p, 1), 0, 0, 0, tg);
      access(slot_addr(p, 2), 0, 0, 0, tg);
    end
  endtask

  initial begin
    void'($urandom(32'd31337));
    for (int i = 0; i < 4096; i++) begin
      dmem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    for (int p = 0; p < 3; p++) mp[p] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", int'(rd_zero_hint), 0, "reset hint");
    read_all("R1");
    // plain
    set_ptr(0, 'h123);
    access(slot_addr(0, 7), 0, 0, 0, "R3");
    access(slot_addr(0, 7), 0, 0, 0, "R3");
    // post-increment wrap to zero, hint stays low
    set_ptr(1, 'hFFF);
    access(slot_addr(1, 5), 0, 0, 0, "R4");
    access(slot_addr(1, 7), 0, 0, 0, "R9");
    // post-decrement wrap
    set_ptr(2, 'h000);
    access(slot_addr(2, 6), 0, 0, 0, "R4");
    access(slot_addr(2, 7), 0, 0, 0, "R4");
    // pre-increment across byte carry
    set_ptr(0, 'h7FF);
    access(slot_addr(0, 4), 0, 0, 0, "R5");
    access(slot_addr(0, 1), 0, 0, 0, "R5");
    access(slot_addr(0, 2), 0, 0, 0, "R5");
    // W-indexed
    set_ptr(1, 'h010);
    access(slot_addr(1, 3), 0, 0, 'hF0, "R6");
    access(slot_addr(1, 3), 1, 'h5A, 'h7F, "R6");
    access(slot_addr(1, 3), 0, 0, 'h7F, "R6");
    set_ptr(1, 'h005);
    access(slot_addr(1, 3), 0, 0, 'h80, "R6");
    access(slot_addr(1, 1), 0, 0, 0, "R6");
    // null read and write through a virtual slot
    set_ptr(2, 'hFEF);
    access(slot_addr(2, 7), 0, 0, 0, "R8");
    access(slot_addr(2, 7), 1, 'hAA, 0, "R8");
    read_all("R8");
    set_ptr(2, 'hFEA);
    access(slot_addr(2, 5), 1, 'h77, 0, "R13");
    read_all("R13");
    // own byte write beats the step
    set_ptr(0, 'hFE9);
    access(slot_addr(0, 5), 1, 'h40, 0, "R10");
    access(slot_addr(0, 1), 0, 0, 0, "R10");
    access(slot_addr(0, 2), 0, 0, 0, "R10");
    // write into another pointer's byte while stepping
    set_ptr(1, 'hFE9);
    access(slot_addr(1, 5), 1, 'h55, 0, "R13");
    read_all("R13");
    // high byte keeps four bits
    access(slot_addr(2, 2), 1, 'hAB, 0, "R12");
    access(slot_addr(2, 2), 0, 0, 0, "R12");
    // direct accesses to the group gaps go to memory
    access('hFE8, 0, 0, 0, "R2");
    access('hFE0, 1, 'h3C, 0, "R2");
    access('hFE0, 0, 0, 0, "R2");
    // random phase
    for (int it = 0; it < 3000; it++) begin
      int r, p, a, v;
      r = $urandom % 10;
      p = $urandom % 3;
      if (r < 2) begin
        if ($urandom % 2) begin
          v = ($urandom % 2) ? 'hF : $urandom % 256;
          access(slot_addr(p, 2), 1, v, 0, "R12");
        end else begin
          v = ($urandom % 2) ? ('hD8 + $urandom % 24) : $urandom % 256;
          access(slot_addr(p, 1), 1, v, 0, "R12");
        end
      end else begin
        a = (r < 6) ? ('hFD8 + $urandom % 24) : ($urandom % 4096);
        access(a, ($urandom % 10) < 3, $urandom % 256, $urandom % 256, "");
      end
      if (it % 200 == 199) read_all("R7");
    end
    read_all("R7");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule